// File: doc/BRIEF.md
# Token-Ring Chip Readout Sequencer

This block runs readout for one front-end chip in a daisy chain whose chips share one open-collector data line. It idles until a start-readout token arrives. The token comes from the acquisition system for the first chip, or from the previous chip's end-readout output for every later chip. The block then shifts its stored event data onto the shared line, one bit per readout clock, and pulls a transmit-on line low for as long as it drives the line. When the last bit has gone out, it emits a one-cycle end-readout pulse, and that pulse becomes the token for the next chip.

There are two start-readout inputs and two end-readout outputs. Two configuration bits choose which input is listened to and which output fires, so the chain can be wired around a dead neighbour. The data line and the transmit-on line each leave the block as two identical lines. Stored words are fetched through a combinational read port into an external event buffer, at a linear address. A chip that holds no events still sends its header and passes the token on.

Top module: `ro_token_ring_ctrl`

## Requirements
- R1: After reset both data lines and both transmit-on lines are released (high), both end-readout outputs are low and the read address is 0.
- R2: A rising edge on the selected start-readout input, seen at a clock edge while the block is idle, starts a frame: transmit-on goes low in the cycle right after that edge and the first frame bit is on the data lines in that same cycle.
- R3: `cfg_in_sel_i` picks the start input (0 selects bit 0, 1 selects bit 1); activity on the other start input never starts a frame.
- R4: A frame is a CNT_W-bit event-count header (CNT_W = clog2(MAX_EVT+1), 4 by default), followed by every stored word in rising address order, each word WORD_W bits wide. Every field is sent MSB first, one bit per clock. Event e occupies addresses e*WPE to e*WPE+WPE-1, with WPE = 1 + 2*NUM_CH: a timestamp word, then a charge word and a time word for each channel.
- R5: A data bit of 1 leaves the data lines released (high) and a 0 pulls them low. Both data lines always carry the same level, and both are released whenever transmit-on is released.
- R6: Both transmit-on lines are low in exactly the cycles that carry frame bits.
- R7: End-readout is a single-cycle high pulse, only on output `cfg_out_sel_i` (0 selects bit 0, 1 selects bit 1). It occurs in the cycle after the last frame bit, the same cycle in which transmit-on is released; the other output stays low.
- R8: With an event count of 0 the frame is only the all-zero header, and it is still followed by the end-readout pulse.
- R9: A start-readout edge that arrives while a frame is being sent has no effect on the frame's content or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_in_sel_i | input | 1 | Chooses which start-readout input is used |
| cfg_out_sel_i | input | 1 | Chooses which end-readout output fires |
| start_ro_i | input | 2 | Redundant start-readout token inputs |
| nevt_i | input | CNT_W | Number of stored events, sampled at start |
| rd_addr_o | output | ADDR_W | Event buffer word address |
| rd_data_i | input | WORD_W | Event buffer word at rd_addr_o (same cycle) |
| dout_o | output | 2 | Redundant data line levels (1 released, 0 pulled low) |
| tx_on_n_o | output | 2 | Redundant transmit-on lines, low while sending |
| end_ro_o | output | 2 | Redundant end-readout token outputs |

## Verification
The bench targets the zero-event frame: a design that skips the header would fire end-readout at once, and one that assumes at least one event would send a spurious word. A start pulse on the deselected lane checks that the bypass actually holds a frame back. A start pulse in the middle of a frame would restart the header if it were not ignored, and the scoreboard would see the wrong bit sequence and length. Frame sizes from one to several events, with swapped lane selections, catch off-by-one bit counts at word and event boundaries, and catch an end pulse that arrives early, arrives late or lands on the wrong lane.

// File: rtl/ro_chain_pkg.sv
package ro_chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_END   = 2'd2
  } ro_state_e;
endpackage

// File: rtl/ro_token_sel.sv
module ro_token_sel (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic [1:0] start_i,
  output logic       trig_o
);
  logic cur, cur_q;

  assign cur = start_i[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= 1'b0;
    else         cur_q <= cur;
  end

  assign trig_o = cur & ~cur_q;
endmodule

// File: rtl/ro_frame_seq.sv
module ro_frame_seq
  import ro_chain_pkg::*;
#(
  parameter int NUM_CH  = 64,
  parameter int MAX_EVT = 15,
  parameter int WORD_W  = 12,
  localparam int CNT_W  = $clog2(MAX_EVT + 1),
  localparam int WPE    = 1 + 2 * NUM_CH,
  localparam int ADDR_W = $clog2(MAX_EVT * WPE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [CNT_W-1:0]  nevt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              load_hdr_o,
  output logic              load_word_o,
  output logic              shift_o,
  output logic              tx_o,
  output logic              end_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int WRD_W = $clog2(WPE);
  localparam logic [BIT_W-1:0] HDR_LAST  = BIT_W'(CNT_W - 1);
  localparam logic [BIT_W-1:0] WORD_LAST = BIT_W'(WORD_W - 1);
  localparam logic [WRD_W-1:0] WRD_LAST  = WRD_W'(WPE - 1);

  ro_state_e         state_q;
  logic [CNT_W-1:0]  nevt_q, evt_q;
  logic [WRD_W-1:0]  wrd_q;
  logic [BIT_W-1:0]  bit_q;
  logic [ADDR_W-1:0] addr_q;
  logic              field_done, more_words;

  assign field_done  = (state_q == ST_SHIFT) && (bit_q == '0);
  assign more_words  = (evt_q != nevt_q);
  assign load_hdr_o  = (state_q == ST_IDLE) && trig_i;
  assign load_word_o = field_done && more_words;
  assign shift_o     = (state_q == ST_SHIFT) && (bit_q != '0);
  assign tx_o        = (state_q == ST_SHIFT);
  assign end_o       = (state_q == ST_END);
  assign addr_o      = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nevt_q  <= '0;
      evt_q   <= '0;
      wrd_q   <= '0;
      bit_q   <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (trig_i) begin
          nevt_q  <= nevt_i;
          evt_q   <= '0;
          wrd_q   <= '0;
          addr_q  <= '0;
          bit_q   <= HDR_LAST;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (bit_q != '0) begin
            bit_q <= bit_q - 1'b1;
          end else if (more_words) begin
            addr_q <= addr_q + 1'b1;
            bit_q  <= WORD_LAST;
            if (wrd_q == WRD_LAST) begin
              wrd_q <= '0;
              evt_q <= evt_q + 1'b1;
            end else begin
              wrd_q <= wrd_q + 1'b1;
            end
          end else begin
            state_q <= ST_END;
          end
        end
        ST_END:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ro_shifter.sv
module ro_shifter #(
  parameter int WORD_W = 12,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_hdr_i,
  input  logic [CNT_W-1:0]  hdr_i,
  input  logic              load_word_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sh_q <= '1;
    else if (load_hdr_i)  sh_q <= {hdr_i, {(WORD_W - CNT_W){1'b0}}};
    else if (load_word_i) sh_q <= word_i;
    else if (shift_i)     sh_q <= {sh_q[WORD_W-2:0], 1'b1};
  end

  assign bit_o = sh_q[WORD_W-1];
endmodule

// File: rtl/ro_line_drv.sv
module ro_line_drv #(
  parameter int LANES = 2
) (
  input  logic             tx_i,
  input  logic             bit_i,
  input  logic             end_i,
  input  logic             out_sel_i,
  output logic [LANES-1:0] dout_o,
  output logic [LANES-1:0] tx_on_n_o,
  output logic [LANES-1:0] end_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dout_o[l]    = ~tx_i | bit_i;
    assign tx_on_n_o[l] = ~tx_i;
    assign end_o[l]     = end_i && (int'(out_sel_i) == l);
  end
endmodule

// File: rtl/ro_token_ring_ctrl.sv
module ro_token_ring_ctrl #(
  parameter int NUM_CH  = 64,
  parameter int MAX_EVT = 15,
  parameter int WORD_W  = 12,
  localparam int CNT_W  = $clog2(MAX_EVT + 1),
  localparam int WPE    = 1 + 2 * NUM_CH,
  localparam int ADDR_W = $clog2(MAX_EVT * WPE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_in_sel_i,
  input  logic              cfg_out_sel_i,
  input  logic [1:0]        start_ro_i,
  input  logic [CNT_W-1:0]  nevt_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [1:0]        dout_o,
  output logic [1:0]        tx_on_n_o,
  output logic [1:0]        end_ro_o
);
  logic trig, load_hdr, load_word, shift, tx, end_p, bit_out;

  ro_token_sel u_tok (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (cfg_in_sel_i),
    .start_i (start_ro_i),
    .trig_o  (trig)
  );

  ro_frame_seq #(.NUM_CH(NUM_CH), .MAX_EVT(MAX_EVT), .WORD_W(WORD_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .nevt_i      (nevt_i),
    .addr_o      (rd_addr_o),
    .load_hdr_o  (load_hdr),
    .load_word_o (load_word),
    .shift_o     (shift),
    .tx_o        (tx),
    .end_o       (end_p)
  );

  ro_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_sh (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_hdr_i  (load_hdr),
    .hdr_i       (nevt_i),
    .load_word_i (load_word),
    .word_i      (rd_data_i),
    .shift_i     (shift),
    .bit_o       (bit_out)
  );

  ro_line_drv #(.LANES(2)) u_drv (
    .tx_i      (tx),
    .bit_i     (bit_out),
    .end_i     (end_p),
    .out_sel_i (cfg_out_sel_i),
    .dout_o    (dout_o),
    .tx_on_n_o (tx_on_n_o),
    .end_o     (end_ro_o)
  );
endmodule

// File: rtl/ro_token_ring_ctrl_chk.sv
module ro_token_ring_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_in_sel_i,
  input logic [1:0] start_ro_i,
  input logic [1:0] dout_o,
  input logic [1:0] tx_on_n_o,
  input logic [1:0] end_ro_o
);
  logic idle;
  assign idle = (tx_on_n_o == 2'b11) && (end_ro_o == 2'b00);

  assert_end_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(end_ro_o));

  assert_end_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_ro_o != 2'b00) |=> (end_ro_o == 2'b00));

  assert_end_after_tx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_ro_o != 2'b00) |-> (tx_on_n_o == 2'b11) && ($past(tx_on_n_o) == 2'b00));

  assert_idle_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_on_n_o == 2'b11) |-> (dout_o == 2'b11));

  assert_tx_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_on_n_o == 2'b00) || (tx_on_n_o == 2'b11));

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_ro_i[cfg_in_sel_i] && !$past(start_ro_i[cfg_in_sel_i]))
      |=> (tx_on_n_o == 2'b00));
endmodule

bind ro_token_ring_ctrl ro_token_ring_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_in_sel_i (cfg_in_sel_i),
  .start_ro_i   (start_ro_i),
  .dout_o       (dout_o),
  .tx_on_n_o    (tx_on_n_o),
  .end_ro_o     (end_ro_o)
);

// File: tb/ro_token_ring_ctrl_tb.sv
module ro_token_ring_ctrl_tb_top;
  localparam int NUM_CH  = 2;
  localparam int MAX_EVT = 15;
  localparam int WORD_W  = 12;
  localparam int CNT_W   = $clog2(MAX_EVT + 1);
  localparam int WPE     = 1 + 2 * NUM_CH;
  localparam int ADDR_W  = $clog2(MAX_EVT * WPE + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_in_sel = 1'b0, cfg_out_sel = 1'b0;
  logic [1:0] start = 2'b00;
  logic [CNT_W-1:0] nevt = '0;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic [1:0] dout, tx_on_n, end_ro;

  int errors = 0, checks = 0;
  bit exp_q[$];
  int end_seen = 0;
  int exp_lane = 0;

  always #2.5 clk = ~clk;

  function automatic logic [WORD_W-1:0] mem_word(int a);
    return WORD_W'((a * 709) ^ 2467);
  endfunction

  assign rd_data = mem_word(int'(rd_addr));

  ro_token_ring_ctrl #(.NUM_CH(NUM_CH), .MAX_EVT(MAX_EVT), .WORD_W(WORD_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_in_sel_i(cfg_in_sel), .cfg_out_sel_i(cfg_out_sel),
    .start_ro_i(start), .nevt_i(nevt), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .dout_o(dout), .tx_on_n_o(tx_on_n), .end_ro_o(end_ro)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_on_n != 2'b11) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6 extra bit", 0, 1);
        end else begin
          automatic bit e = exp_q.pop_front();
          chk(tx_on_n == 2'b00, "R6 tx lanes", tx_on_n, 0);
          chk(dout == {2{e}}, "R4/R5 data bit", dout, {2{e}});
        end
      end
      if (end_ro != 2'b00) begin
        end_seen++;
        chk(end_ro == 2'(1 << exp_lane), "R7 end lane", end_ro, 1 << exp_lane);
        chk(tx_on_n == 2'b11, "R7 tx released with end", tx_on_n, 3);
        chk(exp_q.size() == 0, "R7/R8 end after last bit", exp_q.size(), 0);
      end
    end
  end

  task automatic push_frame(int n);
    for (int b = CNT_W - 1; b >= 0; b--) exp_q.push_back(n[b]);
    for (int a = 0; a < n * WPE; a++) begin
      automatic logic [WORD_W-1:0] w = mem_word(a);
      for (int b = WORD_W - 1; b >= 0; b--) exp_q.push_back(w[b]);
    end
  endtask

  task automatic run_frame(int n, bit isel, bit osel, int disturb_at, string tag);
    automatic int seen0 = end_seen;
    automatic int t = 0;
    cfg_in_sel = isel; cfg_out_sel = osel; exp_lane = osel; nevt = CNT_W'(n);
    push_frame(n);
    start[isel] = 1'b1;
    @(negedge clk);
    start[isel] = 1'b0;
    chk(tx_on_n == 2'b00, {tag, " R2 tx low after start"}, tx_on_n, 0);
    while (end_seen == seen0 && t < 5000) begin
      @(negedge clk);
      t++;
      if (t == disturb_at) start[isel] = 1'b1;
      if (t == disturb_at + 1) start[isel] = 1'b0;
    end
    chk(end_seen == seen0 + 1, {tag, " R7 end pulse seen"}, end_seen - seen0, 1);
    @(negedge clk);
    chk(end_ro == 2'b00 && tx_on_n == 2'b11, {tag, " R7 single pulse, idle"}, {end_ro, tx_on_n}, 3);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dout == 2'b11 && tx_on_n == 2'b11, "R1 lines released in reset", {dout, tx_on_n}, 15);
    chk(end_ro == 2'b00 && rd_addr == '0, "R1 end low, addr 0", {end_ro, 7'(rd_addr)}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_on_n == 2'b11 && dout == 2'b11 && end_ro == 2'b00, "R1 idle after reset", {dout, tx_on_n, end_ro}, 8'h3c);

    run_frame(1, 1'b0, 1'b0, 0, "f1");
    run_frame(3, 1'b1, 1'b0, 0, "f3");
    run_frame(0, 1'b0, 1'b1, 0, "R8 zero-event");
    run_frame(2, 1'b1, 1'b1, 0, "f2");

    // R3: deselected lane ignored
    cfg_in_sel = 1'b0;
    start[1] = 1'b1;
    @(negedge clk);
    start[1] = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(tx_on_n == 2'b11 && end_ro == 2'b00, "R3 other lane ignored", {tx_on_n, end_ro}, 12);
      @(negedge clk);
    end

    // R9: start mid-frame ignored
    run_frame(2, 1'b0, 1'b1, 30, "R9 restart ignored");
    run_frame(MAX_EVT, 1'b1, 1'b0, 100, "full R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule